// File: doc/BRIEF.md
# Super I/O Configuration Unlock Port

This block is the configuration gate of a Super I/O style controller. It occupies two consecutive host I/O addresses: an index address at the strapped base and a data address one above it. After reset the port is locked. It only starts answering once the host writes a fixed four-byte key to the index address. The last byte of that key depends on which of the two bases the part is strapped to.

Once the port is unlocked, the host writes a register number to the index address. It then reads or writes that register through the data address. The register set has two parts:

- **Global registers:** a read-only two-byte chip identifier, a logical-device select, a flash-decode control register and an exit register. Writing the exit value to the exit register locks the port again.
- **Banked registers:** a small register window per logical device. Logical device 7 carries the 16-bit base address of an SPI flash controller, which is driven out to that neighbour.

The host bus is a plain synchronous address/data/strobe interface. Read data is registered.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is locked. `bus_rdata` reads 0xFF, the logical-device select is 0, `spi_base` equals parameter SPI_BASE_RST and `flash_ctl` equals parameter FLASH_CTL_RST.
- R2: The index address is 0x002E when `strap_alt` is 0 and 0x004E when it is 1; the data address is the index address plus one. Accesses to any other address change nothing, and reads of any other address return 0xFF.
- R3: While locked, writing 0x87, 0x01, 0x55 and then a final byte to the index address unlocks the port. The final byte is 0x55 with `strap_alt`=0 and 0xAA with `strap_alt`=1.
- R4: A byte written to the index address that does not match the next expected key byte restarts key matching. If that byte is 0x87 it counts as the first key byte of the new attempt.
- R5: While locked, reads of the index or data address return 0xFF, and data-address writes change no register.
- R6: While unlocked, a write to the index address selects a register. A read of the index address returns that selection, and data-address reads and writes act on the selected register.
- R7: Index 0x20 reads 0x87 and index 0x21 reads 0x16 (chip ID 0x8716). Writes to either have no effect.
- R8: Index 0x07 is the read/write logical-device select. Indices 0x60 to 0x6F form a per-device read/write bank for devices 0 to NUM_LDN-1. With the select at NUM_LDN or above, bank reads return 0x00 and bank writes are ignored.
- R9: In logical device 7, index 0x64 is the high byte and index 0x65 the low byte of `spi_base`.
- R10: Index 0x24 stores bits 5:0 and drives `flash_ctl`: bit 0 suspend, bits 3:1 segment enables, bit 4 host flash write enable, bit 5 flash pin select. Bits 7:6 read as 0.
- R11: Writing 0x02 to index 0x02 locks the port and clears the index selection. Any other value written there has no effect.
- R12: Any other index reads 0x00, and writes to it have no effect.
- R13: A read strobe updates `bus_rdata` at the next clock edge. Without a read strobe, `bus_rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_alt | input | 1 | Base strap: 0 selects 0x2E, 1 selects 0x4E |
| bus_addr | input | 16 | Host I/O address |
| bus_wdata | input | 8 | Host write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Registered read data |
| cfg_unlocked | output | 1 | High while configuration access is open |
| spi_base | output | 16 | SPI controller base address (device 7, 0x64/0x65) |
| flash_ctl | output | 6 | Flash-decode control bits from index 0x24 |

## Verification
The bench overrides SPI_BASE_RST to 0x0A30 and FLASH_CTL_RST to 0x21. This makes the reset values distinguishable from cleared registers and from each other's byte lanes. NUM_LDN stays at 8 while device-select values up to 9 are written, which brings the out-of-range device path into reach. Both strap settings are run, each after its own reset, so both final key bytes and both address pairs are covered. The random phase mixes key fragments, stray bytes and 0x87 restarts against a bench model of the key sequence.

// File: rtl/sio_cfg_pkg.sv
// Package: shared constants for the configuration unlock port.
// Assumes 8-bit registers and 8-bit register indices.
package sio_cfg_pkg;
    localparam logic [7:0] KEY_B0    = 8'h87;
    localparam logic [7:0] KEY_B1    = 8'h01;
    localparam logic [7:0] KEY_B2    = 8'h55;
    localparam logic [7:0] IDX_EXIT  = 8'h02;
    localparam logic [7:0] VAL_EXIT  = 8'h02;
    localparam logic [7:0] IDX_LDN   = 8'h07;
    localparam logic [7:0] IDX_ID_HI = 8'h20;
    localparam logic [7:0] IDX_ID_LO = 8'h21;
    localparam logic [7:0] IDX_FCTL  = 8'h24;
    localparam logic [7:0] IDX_SPI_H = 8'h64;
    localparam logic [7:0] IDX_SPI_L = 8'h65;
    localparam logic [7:0] RD_LOCKED = 8'hFF;
endpackage

// File: rtl/sio_key_unlock.sv
// Module: key sequencer. Tracks the four-byte unlock key written to the index
// address while locked, and holds the unlocked state until a relock request.
// Assumes key_wr is only asserted for index-address writes.
module sio_key_unlock
    import sio_cfg_pkg::*;
#(
    parameter logic [7:0] KEY_LAST_A = 8'h55,
    parameter logic [7:0] KEY_LAST_B = 8'hAA
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strap_alt,
    input  logic       key_wr,
    input  logic [7:0] wdata,
    input  logic       relock,
    output logic       unlocked
);
    logic [1:0] kpos;
    logic [7:0] expect_byte;
    logic [7:0] last_byte;

    // Final key byte follows the base strap.
    assign last_byte = strap_alt ? KEY_LAST_B : KEY_LAST_A;

    // Selects the byte expected at the current key position.
    always_comb begin
        case (kpos)
            2'd0:    expect_byte = KEY_B0;
            2'd1:    expect_byte = KEY_B1;
            2'd2:    expect_byte = KEY_B2;
            default: expect_byte = last_byte;
        endcase
    end

    // Advances, restarts or completes the key match; relock closes the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kpos     <= 2'd0;
            unlocked <= 1'b0;
        end else if (unlocked) begin
            kpos <= 2'd0;
            if (relock) unlocked <= 1'b0;
        end else if (key_wr) begin
            if (wdata == expect_byte) begin
                if (kpos == 2'd3) begin
                    unlocked <= 1'b1;
                    kpos     <= 2'd0;
                end else begin
                    kpos <= kpos + 2'd1;
                end
            end else begin
                kpos <= (wdata == KEY_B0) ? 2'd1 : 2'd0;
            end
        end
    end

    a_r3_unlock_follows_last_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(key_wr && wdata == last_byte));
endmodule

// File: rtl/sio_cfg_regs.sv
// Module: configuration register file. Holds the global registers and one
// bank of registers per logical device, and decodes register reads.
// Assumes reg_wr is only asserted while the port is unlocked.
module sio_cfg_regs
    import sio_cfg_pkg::*;
#(
    parameter logic [15:0] CHIP_ID       = 16'h8716,
    parameter int          NUM_LDN       = 8,
    parameter logic [7:0]  BANK_LO       = 8'h60,
    parameter int          BANK_REGS     = 16,
    parameter int          SPI_LDN       = 7,
    parameter logic [15:0] SPI_BASE_RST  = 16'h0820,
    parameter logic [5:0]  FLASH_CTL_RST = 6'h00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [7:0]  reg_idx,
    input  logic [7:0]  wdata,
    output logic [7:0]  rd_val,
    output logic [15:0] spi_base,
    output logic [5:0]  flash_ctl
);
    localparam int OFF_W  = $clog2(BANK_REGS);
    localparam int LDN_W  = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1;
    localparam int HI_OFF = int'(IDX_SPI_H) - int'(BANK_LO);
    localparam int LO_OFF = int'(IDX_SPI_L) - int'(BANK_LO);

    logic [7:0]       ldn;
    logic [7:0]       rel;
    logic             in_bank;
    logic             ldn_ok;
    logic [OFF_W-1:0] off;
    logic [LDN_W-1:0] ldn_sel;
    logic [7:0]       bank_rd [NUM_LDN];

    assign rel     = reg_idx - BANK_LO;
    assign in_bank = rel < 8'(BANK_REGS);
    assign off     = rel[OFF_W-1:0];
    assign ldn_ok  = ldn < 8'(NUM_LDN);
    assign ldn_sel = ldn[LDN_W-1:0];

    // Global registers: device select and flash-decode control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ldn       <= 8'h00;
            flash_ctl <= FLASH_CTL_RST;
        end else if (reg_wr) begin
            if (reg_idx == IDX_LDN)  ldn       <= wdata;
            if (reg_idx == IDX_FCTL) flash_ctl <= wdata[5:0];
        end
    end

    for (genvar g = 0; g < NUM_LDN; g++) begin : g_bank
        logic [7:0] cells [BANK_REGS];

        // Per-device bank; the SPI device resets its base-address bytes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int k = 0; k < BANK_REGS; k++) begin
                    if (g == SPI_LDN && k == HI_OFF)      cells[k] <= SPI_BASE_RST[15:8];
                    else if (g == SPI_LDN && k == LO_OFF) cells[k] <= SPI_BASE_RST[7:0];
                    else                                  cells[k] <= 8'h00;
                end
            end else if (reg_wr && in_bank && ldn_ok && ldn_sel == LDN_W'(g)) begin
                cells[off] <= wdata;
            end
        end

        assign bank_rd[g] = cells[off];

        if (g == SPI_LDN) begin : g_spi
            assign spi_base = {cells[HI_OFF], cells[LO_OFF]};
        end
    end

    // Read decode of the selected register.
    always_comb begin
        if (in_bank)                     rd_val = ldn_ok ? bank_rd[ldn_sel] : 8'h00;
        else if (reg_idx == IDX_LDN)     rd_val = ldn;
        else if (reg_idx == IDX_ID_HI)   rd_val = CHIP_ID[15:8];
        else if (reg_idx == IDX_ID_LO)   rd_val = CHIP_ID[7:0];
        else if (reg_idx == IDX_FCTL)    rd_val = {2'b00, flash_ctl};
        else                             rd_val = 8'h00;
    end

    a_r8_ldn_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_idx == IDX_LDN) |=> $stable(ldn));
    a_r10_fctl_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_idx == IDX_FCTL) |=> $stable(flash_ctl));
endmodule

// File: rtl/sio_cfg_port.sv
// Module: top of the configuration unlock port. Decodes the strapped
// index/data address pair, keeps the index register and registers read data.
// Assumes one-cycle bus_wr / bus_rd strobes, not both in the same cycle.
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter logic [15:0] BASE_A        = 16'h002E,
    parameter logic [15:0] BASE_B        = 16'h004E,
    parameter logic [7:0]  KEY_LAST_A    = 8'h55,
    parameter logic [7:0]  KEY_LAST_B    = 8'hAA,
    parameter logic [15:0] CHIP_ID       = 16'h8716,
    parameter int          NUM_LDN       = 8,
    parameter logic [7:0]  BANK_LO       = 8'h60,
    parameter int          BANK_REGS     = 16,
    parameter int          SPI_LDN       = 7,
    parameter logic [15:0] SPI_BASE_RST  = 16'h0820,
    parameter logic [5:0]  FLASH_CTL_RST = 6'h00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        strap_alt,
    input  logic [15:0] bus_addr,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_wr,
    input  logic        bus_rd,
    output logic [7:0]  bus_rdata,
    output logic        cfg_unlocked,
    output logic [15:0] spi_base,
    output logic [5:0]  flash_ctl
);
    logic [15:0] idx_addr;
    logic        hit_idx, hit_dat;
    logic [7:0]  idx_q;
    logic [7:0]  reg_val;
    logic        relock;
    logic        data_wr;

    assign idx_addr = strap_alt ? BASE_B : BASE_A;
    assign hit_idx  = bus_addr == idx_addr;
    assign hit_dat  = bus_addr == idx_addr + 16'd1;
    assign data_wr  = bus_wr && hit_dat && cfg_unlocked;
    assign relock   = data_wr && idx_q == IDX_EXIT && bus_wdata == VAL_EXIT;

    sio_key_unlock #(
        .KEY_LAST_A (KEY_LAST_A),
        .KEY_LAST_B (KEY_LAST_B)
    ) u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_alt (strap_alt),
        .key_wr    (bus_wr && hit_idx),
        .wdata     (bus_wdata),
        .relock    (relock),
        .unlocked  (cfg_unlocked)
    );

    sio_cfg_regs #(
        .CHIP_ID       (CHIP_ID),
        .NUM_LDN       (NUM_LDN),
        .BANK_LO       (BANK_LO),
        .BANK_REGS     (BANK_REGS),
        .SPI_LDN       (SPI_LDN),
        .SPI_BASE_RST  (SPI_BASE_RST),
        .FLASH_CTL_RST (FLASH_CTL_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (data_wr),
        .reg_idx   (idx_q),
        .wdata     (bus_wdata),
        .rd_val    (reg_val),
        .spi_base  (spi_base),
        .flash_ctl (flash_ctl)
    );

    // Index register: loaded by unlocked index writes, cleared on relock.
    always_ff @(posedge clk) begin
        if (!rst_n)                              idx_q <= 8'h00;
        else if (relock)                         idx_q <= 8'h00;
        else if (bus_wr && hit_idx && cfg_unlocked) idx_q <= bus_wdata;
    end

    // Read data register: updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= RD_LOCKED;
        end else if (bus_rd) begin
            if (!cfg_unlocked)  bus_rdata <= RD_LOCKED;
            else if (hit_idx)   bus_rdata <= idx_q;
            else if (hit_dat)   bus_rdata <= reg_val;
            else                bus_rdata <= RD_LOCKED;
        end
    end

    a_r5_locked_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !cfg_unlocked) |=> bus_rdata == 8'hFF);
    a_r7_id_high: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && cfg_unlocked && hit_dat && idx_q == IDX_ID_HI) |=> bus_rdata == CHIP_ID[15:8]);
    a_r11_exit_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_unlocked && bus_wr && hit_dat && idx_q == IDX_EXIT && bus_wdata == VAL_EXIT)
        |=> !cfg_unlocked);
    a_r13_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/sio_cfg_port_test.sv
module sio_cfg_port_test;
    localparam logic [15:0] SPI_RST = 16'h0A30;
    localparam logic [5:0]  FCT_RST = 6'h21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_alt = 1'b0;
    logic [15:0] bus_addr = 16'h0;
    logic [7:0]  bus_wdata = 8'h0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        cfg_unlocked;
    logic [15:0] spi_base;
    logic [5:0]  flash_ctl;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Bench model of the port, built from the requirements.
    bit       m_unl;
    int       m_kpos;
    bit [7:0] m_idx, m_ldn;
    bit [5:0] m_ctl;
    bit [7:0] m_bank [8][16];

    always #2.5 clk = ~clk;

    sio_cfg_port #(.SPI_BASE_RST(SPI_RST), .FLASH_CTL_RST(FCT_RST)) uut (
        .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .cfg_unlocked(cfg_unlocked), .spi_base(spi_base), .flash_ctl(flash_ctl));

    function automatic bit [15:0] ia();
        return strap_alt ? 16'h004E : 16'h002E;
    endfunction

    function automatic bit [7:0] key_at(int p);
        case (p)
            0: return 8'h87;
            1: return 8'h01;
            2: return 8'h55;
            default: return strap_alt ? 8'hAA : 8'h55;
        endcase
    endfunction

    function automatic bit [7:0] m_reg();
        if (m_idx >= 8'h60 && m_idx < 8'h70) return (m_ldn < 8) ? m_bank[m_ldn[2:0]][m_idx - 8'h60] : 8'h00;
        case (m_idx)
            8'h07: return m_ldn;
            8'h20: return 8'h87;
            8'h21: return 8'h16;
            8'h24: return {2'b00, m_ctl};
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit [7:0] m_read(bit [15:0] a);
        if (!m_unl) return 8'hFF;
        if (a == ia()) return m_idx;
        if (a == ia() + 16'd1) return m_reg();
        return 8'hFF;
    endfunction

    task automatic m_write(bit [15:0] a, bit [7:0] d);
        if (a == ia()) begin
            if (m_unl) m_idx = d;
            else if (d == key_at(m_kpos)) begin
                if (m_kpos == 3) begin m_unl = 1; m_kpos = 0; end
                else m_kpos++;
            end else m_kpos = (d == 8'h87) ? 1 : 0;
        end else if (a == ia() + 16'd1 && m_unl) begin
            if (m_idx == 8'h02 && d == 8'h02) begin m_unl = 0; m_idx = 0; end
            else if (m_idx == 8'h07) m_ldn = d;
            else if (m_idx == 8'h24) m_ctl = d[5:0];
            else if (m_idx >= 8'h60 && m_idx < 8'h70 && m_ldn < 8) m_bank[m_ldn[2:0]][m_idx - 8'h60] = d;
        end
    endtask

    task automatic m_reset();
        m_unl = 0; m_kpos = 0; m_idx = 0; m_ldn = 0; m_ctl = FCT_RST;
        for (int l = 0; l < 8; l++) for (int k = 0; k < 16; k++) m_bank[l][k] = 8'h00;
        m_bank[7][4] = SPI_RST[15:8];
        m_bank[7][5] = SPI_RST[7:0];
    endtask

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(bit s);
        @(negedge clk);
        rst_n = 0; strap_alt = s;
        repeat (2) @(negedge clk);
        rst_n = 1;
        m_reset();
    endtask

    task automatic bw(bit [15:0] a, bit [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
        m_write(a, d);
    endtask

    task automatic br(bit [15:0] a, string req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        @(negedge clk);
        bus_rd = 0;
        check(req, bus_rdata, m_read(a));
    endtask

    task automatic unlock();
        for (int p = 0; p < 4; p++) bw(ia(), key_at(p));
    endtask

    task automatic sel_rd(bit [7:0] idx, string req);
        bw(ia(), idx);
        br(ia() + 16'd1, req);
    endtask

    task automatic outs(string req);
        check(req, spi_base, {m_bank[7][4], m_bank[7][5]});
        check(req, flash_ctl, m_ctl);
        check(req, cfg_unlocked, m_unl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_2e4e));
        do_reset(1'b0);
        // R1 reset state
        check("R1", bus_rdata, 8'hFF);
        check("R1", spi_base, SPI_RST);
        check("R1", flash_ctl, FCT_RST);
        check("R1", cfg_unlocked, 0);
        // R5 locked: reads 0xFF, data writes dropped
        br(16'h002F, "R5");
        br(16'h002E, "R5");
        bw(16'h002F, 8'h3F);
        outs("R5");
        // R3 unlock at 0x2E
        unlock();
        check("R3", cfg_unlocked, 1);
        // R7 chip ID, read-only
        sel_rd(8'h20, "R7");
        sel_rd(8'h21, "R7");
        bw(16'h002F, 8'h00);
        br(16'h002F, "R7");
        br(16'h002E, "R6");
        // R10 flash control
        sel_rd(8'h24, "R10");
        bw(16'h002F, 8'hFF);
        br(16'h002F, "R10");
        outs("R10");
        // R9 SPI base in device 7
        bw(16'h002E, 8'h07); bw(16'h002F, 8'h07);
        sel_rd(8'h64, "R9");
        bw(16'h002F, 8'hC5);
        sel_rd(8'h65, "R9");
        bw(16'h002F, 8'h3A);
        outs("R9");
        // R8 out-of-range device
        bw(16'h002E, 8'h07); bw(16'h002F, 8'h09);
        sel_rd(8'h64, "R8");
        bw(16'h002F, 8'h77);
        br(16'h002F, "R8");
        outs("R8");
        // R12 unimplemented index
        bw(16'h002E, 8'h55); bw(16'h002F, 8'h12);
        br(16'h002F, "R12");
        // R2 foreign address ignored
        bw(16'h004F, 8'h02);
        br(16'h004E, "R2");
        // R11 non-exit value, then exit
        bw(16'h002E, 8'h02); bw(16'h002F, 8'h03);
        check("R11", cfg_unlocked, 1);
        bw(16'h002F, 8'h02);
        check("R11", cfg_unlocked, 0);
        br(16'h002F, "R11");
        // R4 restart with 0x87 inside the key
        bw(16'h002E, 8'h87); bw(16'h002E, 8'h87);
        bw(16'h002E, 8'h01); bw(16'h002E, 8'h55); bw(16'h002E, 8'h55);
        check("R4", cfg_unlocked, 1);
        br(16'h002E, "R11");

        // Strap 1: 0x55 final byte must fail, 0xAA succeeds
        do_reset(1'b1);
        bw(16'h004E, 8'h87); bw(16'h004E, 8'h01); bw(16'h004E, 8'h55); bw(16'h004E, 8'h55);
        check("R3", cfg_unlocked, 0);
        bw(16'h002E, 8'h87); bw(16'h002E, 8'h01); bw(16'h002E, 8'h55); bw(16'h002E, 8'h55);
        check("R2", cfg_unlocked, 0);
        unlock();
        check("R3", cfg_unlocked, 1);
        sel_rd(8'h20, "R2");
        // R13 rdata holds without a read strobe
        repeat (3) @(negedge clk);
        check("R13", bus_rdata, 8'h87);

        // Random phase against the model
        for (int s = 0; s < 2; s++) begin
            do_reset(s[0]);
            for (int i = 0; i < 3000; i++) begin
                int r;
                bit [7:0] d;
                r = int'($urandom_range(99));
                if (r < 35) begin
                    if (!m_unl) d = ($urandom_range(9) < 7) ? key_at(m_kpos) : 8'($urandom);
                    else case ($urandom_range(7))
                        0: d = 8'h02; 1: d = 8'h07; 2: d = 8'h20; 3: d = 8'h24;
                        4: d = 8'h64; 5: d = 8'h65; 6: d = 8'h60 + 8'($urandom_range(15));
                        default: d = 8'($urandom);
                    endcase
                    bw(ia(), d);
                end else if (r < 60) begin
                    if (m_idx == 8'h07) d = 8'($urandom_range(9));
                    else if (m_idx == 8'h02) d = ($urandom_range(3) == 0) ? 8'h02 : 8'($urandom);
                    else d = 8'($urandom);
                    bw(ia() + 16'd1, d);
                end else if (r < 85) br(ia() + 16'd1, "R6");
                else if (r < 93) br(ia(), "R6");
                else br(16'($urandom_range(16'h00FF)), "R2");
                if (i % 50 == 0) outs("R9");
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule